// File: doc/BRIEF.md
# Branch Link and Count Register Pair

This block keeps the two registers a branch unit uses for calls, returns and counted loops. The link register saves the next sequential instruction address for any branch that asks to link, and it serves as the target of a branch-to-link-register operation. The count register holds a loop count that a branch can decrement. A zero flag reports whether the count reaches zero after that decrement, so the branch condition logic can use it in the same cycle.

Software reaches both registers through a special-register port. A write takes effect at the clock edge. A read returns its data one cycle later. Reset clears only the read-data register. Neither architectural register has a reset value. Each keeps whatever it held before reset, so software must load both before it relies on them.

Top module: `branch_link_count`

## Requirements
- R1: Reset clears `spr_rdata` to zero. Reset leaves the link and count contents unchanged, and a read after reset returns the values written before it.
- R2: When `br_valid` and `br_link` are both 1, the link register takes `br_next_pc` at the clock edge. This happens whatever the value of `br_taken`.
- R3: A software write stores all 32 bits, including the two low link bits, and a later read returns them unchanged.
- R4: `redirect_valid` equals `br_valid & br_to_lr & br_taken` in the same cycle. `redirect_addr` is the current link value with bits [1:0] forced to zero.
- R5: When `br_valid` and `br_dec_ctr` are both 1, the count register takes its old value minus one at the clock edge, wrapping from 0 to 32'hFFFF_FFFF.
- R6: In the same cycle, `ctr_zero` is 1 exactly when the post-decrement count is zero if a decrement is requested, and when the current count is zero otherwise.
- R7: A branch that both uses the link register as its target and links gets the old link value as its target. The new link value is visible from the next cycle on.
- R8: A software write wins over a branch update to the same register in the same cycle. A branch update to the other register still takes place. Select code 0 is the link register and 1 is the count register.
- R9: When `spr_rd_en` is 1, `spr_rdata` shows the selected register's value from just before that edge, starting one cycle later. A write in the same cycle is not seen.
- R10: When `br_valid` is 0, `br_link`, `br_dec_ctr` and `br_next_pc` change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| br_valid | input | 1 | A branch executes this cycle |
| br_link | input | 1 | The branch saves its return address |
| br_dec_ctr | input | 1 | The branch decrements the count |
| br_taken | input | 1 | Branch resolved as taken |
| br_to_lr | input | 1 | The branch takes its target from the link register |
| br_next_pc | input | 32 | Address of the next sequential instruction |
| spr_wr_en | input | 1 | Software write strobe |
| spr_wr_sel | input | 1 | Write select: 0 link, 1 count |
| spr_wdata | input | 32 | Software write data |
| spr_rd_en | input | 1 | Software read strobe |
| spr_rd_sel | input | 1 | Read select: 0 link, 1 count |
| spr_rdata | output | 32 | Registered read data |
| redirect_valid | output | 1 | Taken branch to the link register |
| redirect_addr | output | 32 | Word-aligned link target |
| ctr_zero | output | 1 | Post-decrement count is zero |

## Verification
Linking branches are tried both taken and not taken, to confirm that capture does not depend on the branch outcome. The count is stepped down through 1 and 0 and then past 0, which checks the zero flag on both sides of zero and the wrap. Some cycles put a software write and a branch update on the same register, and others put them on different registers. These cycles separate a correct priority from lost updates. A last group drives link and decrement requests while `br_valid` is low, and another reads and writes the same register in one cycle. Together they confirm that the branch qualifier is honoured and that reads return the pre-edge value.

// File: rtl/blc_pkg.sv
package blc_pkg;
  // Special-register select codes shared by both ports.
  typedef enum logic {
    SEL_LINK  = 1'b0,
    SEL_COUNT = 1'b1
  } spr_sel_e;
endpackage

// File: rtl/blc_rst_sync.sv
module blc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/blc_link_reg.sv
module blc_link_reg #(
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              br_we,
  input  logic [DATA_W-1:0] br_wdata,
  output logic [DATA_W-1:0] lr_q,
  output logic [DATA_W-1:0] tgt_addr
);
  logic              lr_en;
  logic [DATA_W-1:0] lr_d;

  // Software write has priority over branch capture.
  always_comb begin
    lr_en = sw_we | br_we;
    lr_d  = sw_we ? sw_wdata : br_wdata;
  end

  // No reset: contents survive reset.
  always_ff @(posedge clk) begin
    if (lr_en) lr_q <= lr_d;
  end

  generate
    if (ALIGN_W > 0) begin : g_mask
      assign tgt_addr = {lr_q[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end else begin : g_nomask
      assign tgt_addr = lr_q;
    end
  endgenerate
endmodule

// File: rtl/blc_count_reg.sv
module blc_count_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              dec_req,
  output logic [DATA_W-1:0] ctr_q,
  output logic              zero
);
  logic              ctr_en;
  logic [DATA_W-1:0] ctr_d;
  logic [DATA_W-1:0] dec_val;

  always_comb begin
    dec_val = ctr_q - DATA_W'(1);
    ctr_en  = sw_we | dec_req;
    ctr_d   = sw_we ? sw_wdata : dec_val;
    zero    = dec_req ? (dec_val == '0) : (ctr_q == '0);
  end

  always_ff @(posedge clk) begin
    if (ctr_en) ctr_q <= ctr_d;
  end
endmodule

// File: rtl/blc_read_port.sv
module blc_read_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  blc_pkg::spr_sel_e rd_sel,
  input  logic [DATA_W-1:0] lr_val,
  input  logic [DATA_W-1:0] ctr_val,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = (rd_sel == blc_pkg::SEL_COUNT) ? ctr_val : lr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/branch_link_count.sv
module branch_link_count #(
  parameter int DATA_W      = 32,
  parameter int ALIGN_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_link,
  input  logic              br_dec_ctr,
  input  logic              br_taken,
  input  logic              br_to_lr,
  input  logic [DATA_W-1:0] br_next_pc,
  input  logic              spr_wr_en,
  input  logic              spr_wr_sel,
  input  logic [DATA_W-1:0] spr_wdata,
  input  logic              spr_rd_en,
  input  logic              spr_rd_sel,
  output logic [DATA_W-1:0] spr_rdata,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_addr,
  output logic              ctr_zero
);
  import blc_pkg::*;

  logic              rst_sync_n;
  spr_sel_e          wr_sel;
  spr_sel_e          rd_sel;
  logic              sw_lr_we;
  logic              sw_ctr_we;
  logic              br_lr_we;
  logic              br_ctr_dec;
  logic [DATA_W-1:0] lr_q;
  logic [DATA_W-1:0] ctr_q;

  always_comb begin
    wr_sel         = spr_sel_e'(spr_wr_sel);
    rd_sel         = spr_sel_e'(spr_rd_sel);
    sw_lr_we       = spr_wr_en & (wr_sel == SEL_LINK);
    sw_ctr_we      = spr_wr_en & (wr_sel == SEL_COUNT);
    br_lr_we       = br_valid & br_link;
    br_ctr_dec     = br_valid & br_dec_ctr;
    redirect_valid = br_valid & br_to_lr & br_taken;
  end

  blc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  blc_link_reg #(.DATA_W(DATA_W), .ALIGN_W(ALIGN_W)) u_link (
    .clk      (clk),
    .sw_we    (sw_lr_we),
    .sw_wdata (spr_wdata),
    .br_we    (br_lr_we),
    .br_wdata (br_next_pc),
    .lr_q     (lr_q),
    .tgt_addr (redirect_addr)
  );

  blc_count_reg #(.DATA_W(DATA_W)) u_count (
    .clk      (clk),
    .sw_we    (sw_ctr_we),
    .sw_wdata (spr_wdata),
    .dec_req  (br_ctr_dec),
    .ctr_q    (ctr_q),
    .zero     (ctr_zero)
  );

  blc_read_port #(.DATA_W(DATA_W)) u_read (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (spr_rd_en),
    .rd_sel  (rd_sel),
    .lr_val  (lr_q),
    .ctr_val (ctr_q),
    .rdata   (spr_rdata)
  );
endmodule

// File: rtl/blc_checker.sv
module blc_checker #(
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic              br_link,
  input logic              br_dec_ctr,
  input logic [DATA_W-1:0] br_next_pc,
  input logic              spr_wr_en,
  input logic              spr_wr_sel,
  input logic [DATA_W-1:0] spr_wdata,
  input logic              spr_rd_en,
  input logic              spr_rd_sel,
  input logic [DATA_W-1:0] spr_rdata,
  input logic              redirect_valid,
  input logic [DATA_W-1:0] redirect_addr,
  input logic              ctr_zero,
  input logic [DATA_W-1:0] lr_q,
  input logic [DATA_W-1:0] ctr_q
);
  logic sw_lr;
  logic sw_ctr;
  assign sw_lr  = spr_wr_en && (spr_wr_sel == 1'b0);
  assign sw_ctr = spr_wr_en && (spr_wr_sel == 1'b1);

  p_link_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_link && !sw_lr |=> lr_q == $past(br_next_pc));

  p_sw_link_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_lr |=> lr_q == $past(spr_wdata));

  p_sw_count_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ctr |=> ctr_q == $past(spr_wdata));

  p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_dec_ctr && !sw_ctr |=> ctr_q == $past(ctr_q) - DATA_W'(1));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_dec_ctr && !sw_ctr |=> (ctr_q == '0) == $past(ctr_zero));

  p_no_branch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid && !spr_wr_en |=> $stable(lr_q) && $stable(ctr_q));

  p_target_after_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_link && !sw_lr) ##1 redirect_valid
      |-> redirect_addr[DATA_W-1:ALIGN_W] == $past(br_next_pc[DATA_W-1:ALIGN_W]));

  p_read_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(spr_rd_en)
      |-> spr_rdata == $past(spr_rd_sel ? ctr_q : lr_q));
endmodule

bind branch_link_count blc_checker #(.DATA_W(DATA_W), .ALIGN_W(ALIGN_W)) u_blc_checker (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .br_valid       (br_valid),
  .br_link        (br_link),
  .br_dec_ctr     (br_dec_ctr),
  .br_next_pc     (br_next_pc),
  .spr_wr_en      (spr_wr_en),
  .spr_wr_sel     (spr_wr_sel),
  .spr_wdata      (spr_wdata),
  .spr_rd_en      (spr_rd_en),
  .spr_rd_sel     (spr_rd_sel),
  .spr_rdata      (spr_rdata),
  .redirect_valid (redirect_valid),
  .redirect_addr  (redirect_addr),
  .ctr_zero       (ctr_zero),
  .lr_q           (lr_q),
  .ctr_q          (ctr_q)
);

// File: tb/tb_branch_link_count.sv
module tb_branch_link_count;
  logic        clk;
  logic        rst_n;
  logic        br_valid, br_link, br_dec_ctr, br_taken, br_to_lr;
  logic [31:0] br_next_pc;
  logic        spr_wr_en, spr_wr_sel;
  logic [31:0] spr_wdata;
  logic        spr_rd_en, spr_rd_sel;
  logic [31:0] spr_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_addr;
  logic        ctr_zero;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  branch_link_count dut (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_link(br_link), .br_dec_ctr(br_dec_ctr),
    .br_taken(br_taken), .br_to_lr(br_to_lr), .br_next_pc(br_next_pc),
    .spr_wr_en(spr_wr_en), .spr_wr_sel(spr_wr_sel), .spr_wdata(spr_wdata),
    .spr_rd_en(spr_rd_en), .spr_rd_sel(spr_rd_sel), .spr_rdata(spr_rdata),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .ctr_zero(ctr_zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        wsel;
    logic [31:0] wdata;
    logic        bv, bl, bd, bt, btl;
    logic [31:0] npc;
    logic        rd, rsel;
    logic        chk;
    logic [31:0] erd;
    logic        ev;
    logic [31:0] eaddr;
    logic        cz, ez;
  } vec_t;

  localparam int NV = 15;
  // wr wsel wdata | bv bl bd bt btl npc | rd rsel | chk erd | ev eaddr | cz ez
  localparam vec_t VEC [NV] = '{
    // 0: load link with low bits set (R3)
    '{1'b1,1'b0,32'h1000_0003, 1'b0,1'b0,1'b0,1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b0,32'h0, 1'b0,32'h0, 1'b0,1'b0},
    // 1: load count = 2, read link
    '{1'b1,1'b1,32'h2, 1'b0,1'b0,1'b0,1'b0,1'b0,32'h0, 1'b1,1'b0, 1'b0,32'h0, 1'b0,32'h0, 1'b0,1'b0},
    // 2: link reads back with low bits (R3); read count
    '{1'b0,1'b0,32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,32'h0, 1'b1,1'b1, 1'b1,32'h1000_0003, 1'b0,32'h0, 1'b1,1'b0},
    // 3: taken return, masked target (R4), decrement 2->1 (R6)
    '{1'b0,1'b0,32'h0, 1'b1,1'b0,1'b1,1'b1,1'b1,32'h2000_0010, 1'b0,1'b0, 1'b1,32'h2, 1'b1,32'h1000_0000, 1'b1,1'b0},
    // 4: not-taken linking branch still links (R2), decrement 1->0 flags zero (R6)
    '{1'b0,1'b0,32'h0, 1'b1,1'b1,1'b1,1'b0,1'b1,32'h3000_0004, 1'b0,1'b0, 1'b0,32'h0, 1'b0,32'h0, 1'b1,1'b1},
    // 5: return plus link: old link value is target (R7)
    '{1'b0,1'b0,32'h0, 1'b1,1'b1,1'b0,1'b1,1'b1,32'h4000_0008, 1'b0,1'b0, 1'b0,32'h0, 1'b1,32'h3000_0004, 1'b1,1'b1},
    // 6: decrement from 0 wraps (R5)
    '{1'b0,1'b0,32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,32'h0, 1'b1,1'b0, 1'b0,32'h0, 1'b0,32'h0, 1'b1,1'b0},
    // 7: link holds new value (R7)
    '{1'b0,1'b0,32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,32'h0, 1'b1,1'b1, 1'b1,32'h4000_0008, 1'b0,32'h0, 1'b1,1'b0},
    // 8: count wrapped (R5); sw count write beats decrement, link still captured (R8)
    '{1'b1,1'b1,32'h5, 1'b1,1'b1,1'b1,1'b0,1'b0,32'h5000_0000, 1'b0,1'b0, 1'b1,32'hFFFF_FFFF, 1'b0,32'h0, 1'b1,1'b0},
    // 9: sw link write beats branch link (R8); read link
    '{1'b1,1'b0,32'hABCD_EF01, 1'b1,1'b1,1'b0,1'b0,1'b0,32'h6000_0000, 1'b1,1'b0, 1'b0,32'h0, 1'b0,32'h0, 1'b1,1'b0},
    // 10: branch link of cycle 8 landed (R8); return uses sw value (R4)
    '{1'b0,1'b0,32'h0, 1'b1,1'b0,1'b0,1'b1,1'b1,32'h0, 1'b1,1'b1, 1'b1,32'h5000_0000, 1'b1,32'hABCD_EF00, 1'b1,1'b0},
    // 11: count is the sw value (R8)
    '{1'b0,1'b0,32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,32'h0, 1'b1,1'b0, 1'b1,32'h5, 1'b0,32'h0, 1'b1,1'b0},
    // 12: link is the sw value (R8); requests without br_valid (R10)
    '{1'b0,1'b0,32'h0, 1'b0,1'b1,1'b1,1'b1,1'b1,32'h7777_7777, 1'b1,1'b0, 1'b1,32'hABCD_EF01, 1'b0,32'h0, 1'b1,1'b0},
    // 13: link untouched (R10)
    '{1'b0,1'b0,32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,32'h0, 1'b1,1'b1, 1'b1,32'hABCD_EF01, 1'b0,32'h0, 1'b1,1'b0},
    // 14: count untouched (R10)
    '{1'b0,1'b0,32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b1,32'h5, 1'b0,32'h0, 1'b1,1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    br_valid = 0; br_link = 0; br_dec_ctr = 0; br_taken = 0; br_to_lr = 0;
    br_next_pc = '0; spr_wr_en = 0; spr_wr_sel = 0; spr_wdata = '0;
    spr_rd_en = 0; spr_rd_sel = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 read data after reset", spr_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      spr_wr_en = VEC[i].wr;  spr_wr_sel = VEC[i].wsel; spr_wdata = VEC[i].wdata;
      br_valid = VEC[i].bv;   br_link = VEC[i].bl;      br_dec_ctr = VEC[i].bd;
      br_taken = VEC[i].bt;   br_to_lr = VEC[i].btl;    br_next_pc = VEC[i].npc;
      spr_rd_en = VEC[i].rd;  spr_rd_sel = VEC[i].rsel;
      #1;
      check("R4 redirect_valid", {31'b0, redirect_valid}, {31'b0, VEC[i].ev});
      if (VEC[i].ev) check("R4 redirect_addr", redirect_addr, VEC[i].eaddr);
      if (VEC[i].cz) check("R6 ctr_zero", {31'b0, ctr_zero}, {31'b0, VEC[i].ez});
      if (VEC[i].chk) check("R9 read data", spr_rdata, VEC[i].erd);
    end

    // R9: same-cycle write and read of link returns pre-edge value
    @(negedge clk);
    idle();
    spr_wr_en = 1; spr_wr_sel = 0; spr_wdata = 32'h1111_1112;
    spr_rd_en = 1; spr_rd_sel = 0;
    @(negedge clk);
    idle();
    check("R9 read before same-cycle write", spr_rdata, 32'hABCD_EF01);
    spr_rd_en = 1; spr_rd_sel = 0;
    @(negedge clk);
    idle();
    check("R3 link low bits kept", spr_rdata, 32'h1111_1112);

    // R1: reset keeps both registers
    rst_n = 0;
    #1;
    check("R1 read data cleared in reset", spr_rdata, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 read data zero after reset", spr_rdata, 32'h0);
    spr_rd_en = 1; spr_rd_sel = 0;
    @(negedge clk);
    check("R1 link kept across reset", spr_rdata, 32'h1111_1112);
    spr_rd_sel = 1;
    @(negedge clk);
    idle();
    check("R1 count kept across reset", spr_rdata, 32'h5);
    #1;
    check("R6 ctr_zero idle nonzero", {31'b0, ctr_zero}, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule